// File: doc/BRIEF.md
# EDO Page-Mode DRAM Access Sequencer

This block sits on the controller side of a 1M x 4 extended-data-out DRAM and produces the row strobe, column strobe, write enable, output enable and the shared 10-bit address bus. A host hands it one access at a time over a valid/ready handshake: a 20-bit word address, a write flag, a write-style select and 4 bits of write data. Reads come back on a data port qualified by a one-cycle valid pulse.

Once a row is activated it stays open. A later request to the same row runs only a column cycle, and reads and writes can be mixed freely inside one open row. A request to another row first closes the open row, waits out the precharge and then activates the new row. An open row is also closed on its own before it reaches the longest allowed row-strobe low time. An external scheduler requests a refresh on a separate handshake. The sequencer serves it between host accesses as a column-before-row refresh, after it has closed any open row. Every timing minimum is a parameter given in clock cycles.

Top module: `edo_dram_seq`

## Requirements
- R1: While rst_ni is low, the row, column, write and output strobes are all high (inactive), dram_dq_oe_o, rd_valid_o and ref_ack_o are 0. After reset, req_ready_o is 1 when no refresh is requested.
- R2: The row address req_addr_i[19:10] is on dram_addr_o when the row strobe falls, and the column address req_addr_i[9:0] is on it when the column strobe falls.
- R3: Each row activation keeps the row strobe high for at least T_RP cycles before it falls. The row strobe stays low for at least T_RAS cycles, and the column strobe falls at least T_RCD cycles after the row strobe.
- R4: A request to the open row produces no row-strobe edge. Each column strobe low phase lasts at least T_CAS cycles, and each high phase between column accesses lasts at least T_CP cycles.
- R5: A request to a row other than the open one raises the row strobe, meets precharge and activates the new row, so exactly one new row-strobe fall occurs.
- R6: The row strobe never stays low longer than T_RAS_MAX cycles. An idle open row is closed without a host request.
- R7: Read data is captured on the clock edge at which the column strobe rises. rd_valid_o is high for exactly that one cycle.
- R8: With req_early_i=1, a write drives write enable low and the data at least one cycle before the column strobe falls, and keeps output enable high.
- R9: With req_early_i=0, a write lets the column strobe fall with write enable high. It then drives write enable low together with the data. dram_dq_oe_o is never 1 while output enable is low.
- R10: A refresh request is acknowledged with a one-cycle ref_ack_o only while no host access is in flight and the row is closed. It then runs a cycle in which the column strobe falls before the row strobe.
- R11: After the last column-strobe fall of an open row, the row strobe stays low for at least T_CSH cycles.
- R12: A read returns the data most recently written to the same address, across mixed early writes, delayed writes and reads in both open and newly opened rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Request accepted on this cycle when valid |
| req_addr_i | input | 20 | Word address, row in [19:10], column in [9:0] |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_early_i | input | 1 | Write style: 1 = early write, 0 = delayed write |
| req_wdata_i | input | 4 | Write data |
| rd_valid_o | output | 1 | Read data valid pulse |
| rd_data_o | output | 4 | Read data |
| ref_req_i | input | 1 | Refresh request, held until acknowledged |
| ref_ack_o | output | 1 | Refresh accepted |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_cas_no | output | 1 | Column strobe, active low |
| dram_we_no | output | 1 | Write enable, active low |
| dram_oe_no | output | 1 | Output enable, active low |
| dram_addr_o | output | 10 | Multiplexed row/column address |
| dram_dq_o | output | 4 | Write data to the pads |
| dram_dq_oe_o | output | 1 | Pad driver enable for write data |
| dram_dq_i | input | 4 | Read data from the pads |

## Verification
With the default column timing, a read to the open row is accepted on edge E0. The column strobe falls on E2, and rd_valid_o with the captured data appears on E3, which is the same edge at which the column strobe rises. A row miss adds the close, precharge and activate phases in front of that. The bench does not predict a fixed latency. It keeps expected read values in a queue and checks each one at the valid pulse, together with a check that the column strobe rose in that same cycle. A behavioural DRAM model samples the pins midway between edges and counts cycles between strobe edges, so every timing minimum and maximum is checked against the parameters rather than against a latency.

// File: rtl/edo_seq_pkg.sv
package edo_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_ACT,
    S_CSET,
    S_CASL,
    S_DWR,
    S_CASH,
    S_CLOSE,
    S_PRE,
    S_RCAS,
    S_RRAS
  } seq_state_e;
endpackage

// File: rtl/edo_seq_timer.sv
module edo_seq_timer #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/edo_seq_row_trk.sv
module edo_seq_row_trk #(
  parameter int RW        = 10,
  parameter int T_RAS     = 6,
  parameter int T_CSH     = 5,
  parameter int T_RAS_MAX = 10000,
  parameter int EXP_AT    = 9980
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          open_i,
  input  logic          close_i,
  input  logic          cas_fall_i,
  input  logic [RW-1:0] row_i,
  output logic          open_o,
  output logic          hit_o,
  output logic          expire_o,
  output logic          close_ok_o
);
  localparam int AGW = $clog2(T_RAS_MAX + 1) + 1;
  localparam int CGW = $clog2(T_CSH + 1) + 1;
  localparam logic [AGW-1:0] AGE_SAT = AGW'(T_RAS_MAX);
  localparam logic [AGW-1:0] EXP_V   = AGW'(EXP_AT);
  localparam logic [AGW-1:0] RAS_V   = AGW'(T_RAS - 1);
  localparam logic [CGW-1:0] CSH_SAT = CGW'(T_CSH);
  localparam logic [CGW-1:0] CSH_V   = CGW'(T_CSH - 1);

  logic          open_q;
  logic [RW-1:0] row_q;
  logic [AGW-1:0] age_q;
  logic [CGW-1:0] cag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else if (open_i) begin
      open_q <= 1'b1;
      row_q  <= row_i;
    end else if (close_i) begin
      open_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           age_q <= '0;
    else if (open_i)                       age_q <= '0;
    else if (open_q && age_q != AGE_SAT)   age_q <= age_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           cag_q <= '0;
    else if (cas_fall_i || open_i)         cag_q <= '0;
    else if (cag_q != CSH_SAT)             cag_q <= cag_q + 1'b1;
  end

  assign open_o     = open_q;
  assign expire_o   = open_q && (age_q >= EXP_V);
  assign hit_o      = open_q && (row_q == row_i) && !expire_o;
  assign close_ok_o = open_q && (age_q >= RAS_V) && (cag_q >= CSH_V);

  // R6
  ras_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_q |-> (age_q < AGE_SAT));

  // R11
  csh_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(open_q) |-> ($past(cag_q) >= CSH_V));
endmodule

// File: rtl/edo_seq_rd_cap.sv
module edo_seq_rd_cap #(
  parameter int DW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic [DW-1:0] dq_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= cap_i;
      if (cap_i) data_o <= dq_i;
    end
  end

  // R7
  rd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: rtl/edo_dram_seq.sv
module edo_dram_seq #(
  parameter int AW        = 20,
  parameter int DW        = 4,
  parameter int T_RP      = 4,
  parameter int T_RCD     = 2,
  parameter int T_RAS     = 6,
  parameter int T_CAS     = 1,
  parameter int T_CP      = 1,
  parameter int T_CSH     = 5,
  parameter int T_WP      = 1,
  parameter int T_CSR     = 1,
  parameter int T_RAS_MAX = 10000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_addr_i,
  input  logic          req_we_i,
  input  logic          req_early_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o,
  input  logic          ref_req_i,
  output logic          ref_ack_o,
  output logic          dram_ras_no,
  output logic          dram_cas_no,
  output logic          dram_we_no,
  output logic          dram_oe_no,
  output logic [AW/2-1:0] dram_addr_o,
  output logic [DW-1:0] dram_dq_o,
  output logic          dram_dq_oe_o,
  input  logic [DW-1:0] dram_dq_i
);
  import edo_seq_pkg::*;

  localparam int RW     = AW / 2;
  localparam int TW     = $clog2(T_RP + T_RCD + T_RAS + T_CAS + T_CP + T_WP + T_CSR + 2);
  // worst-case cycles from an expiry check to the row strobe rising
  localparam int EXP_AT = T_RAS_MAX - (T_CAS + T_WP + T_CP + T_CSH + 6);

  seq_state_e    st_q, st_d;
  logic          pend_q;
  logic [AW-1:0] addr_q;
  logic          we_q, early_q;
  logic [DW-1:0] wd_q;

  logic          tmr_ld, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic          row_open, row_hit, row_exp, close_ok;
  logic          open_s, close_s, cap_s, cas_fall_s;
  logic          accept;

  edo_seq_timer #(.TW(TW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_ld),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  edo_seq_row_trk #(
    .RW(RW), .T_RAS(T_RAS), .T_CSH(T_CSH), .T_RAS_MAX(T_RAS_MAX), .EXP_AT(EXP_AT)
  ) u_row (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .open_i     (open_s),
    .close_i    (close_s),
    .cas_fall_i (cas_fall_s),
    .row_i      (addr_q[AW-1:RW]),
    .open_o     (row_open),
    .hit_o      (row_hit),
    .expire_o   (row_exp),
    .close_ok_o (close_ok)
  );

  edo_seq_rd_cap #(.DW(DW)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (cap_s),
    .dq_i    (dram_dq_i),
    .valid_o (rd_valid_o),
    .data_o  (rd_data_o)
  );

  assign req_ready_o = (st_q == S_IDLE) && !pend_q && !ref_req_i && !(row_open && row_exp);
  assign ref_ack_o   = (st_q == S_IDLE) && !pend_q && !row_open && ref_req_i;
  assign accept      = req_valid_i && req_ready_o;
  assign cas_fall_s  = (st_q == S_CSET);

  always_comb begin
    st_d    = st_q;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    open_s  = 1'b0;
    close_s = 1'b0;
    cap_s   = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (pend_q) begin
          if (row_hit) st_d = S_CSET;
          else if (row_open) st_d = S_CLOSE;
          else begin
            st_d = S_ACT; open_s = 1'b1;
            tmr_ld = 1'b1; tmr_val = TW'(T_RCD - 1);
          end
        end else if (row_open && (ref_req_i || row_exp)) begin
          st_d = S_CLOSE;
        end else if (ref_req_i) begin
          st_d = S_RCAS; tmr_ld = 1'b1; tmr_val = TW'(T_CSR - 1);
        end
      end
      S_ACT: if (tmr_zero) st_d = S_CSET;
      S_CSET: begin
        st_d = S_CASL; tmr_ld = 1'b1; tmr_val = TW'(T_CAS - 1);
      end
      S_CASL: if (tmr_zero) begin
        if (we_q && !early_q) begin
          st_d = S_DWR; tmr_ld = 1'b1; tmr_val = TW'(T_WP - 1);
        end else begin
          st_d = S_CASH; tmr_ld = 1'b1; tmr_val = TW'(T_CP - 1);
          cap_s = !we_q;
        end
      end
      S_DWR: if (tmr_zero) begin
        st_d = S_CASH; tmr_ld = 1'b1; tmr_val = TW'(T_CP - 1);
      end
      S_CASH: if (tmr_zero) st_d = S_IDLE;
      S_CLOSE: if (close_ok) begin
        st_d = S_PRE; close_s = 1'b1;
        tmr_ld = 1'b1; tmr_val = TW'(T_RP - 1);
      end
      S_PRE: if (tmr_zero) st_d = S_IDLE;
      S_RCAS: if (tmr_zero) begin
        st_d = S_RRAS; tmr_ld = 1'b1; tmr_val = TW'(T_RAS - 1);
      end
      S_RRAS: if (tmr_zero) begin
        st_d = S_PRE; tmr_ld = 1'b1; tmr_val = TW'(T_RP - 1);
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      pend_q  <= 1'b0;
      addr_q  <= '0;
      we_q    <= 1'b0;
      early_q <= 1'b0;
      wd_q    <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        pend_q  <= 1'b1;
        addr_q  <= req_addr_i;
        we_q    <= req_we_i;
        early_q <= req_early_i;
        wd_q    <= req_wdata_i;
      end else if (st_q == S_CSET) begin
        pend_q  <= 1'b0;
      end
    end
  end

  logic col_ph, cas_low, we_low;
  assign col_ph  = (st_q == S_CSET) || (st_q == S_CASL) || (st_q == S_DWR);
  assign cas_low = (st_q == S_CASL) || (st_q == S_DWR) || (st_q == S_RCAS) || (st_q == S_RRAS);
  assign we_low  = (we_q && early_q && ((st_q == S_CSET) || (st_q == S_CASL))) || (st_q == S_DWR);

  assign dram_ras_no  = !(row_open || (st_q == S_RRAS));
  assign dram_cas_no  = !cas_low;
  assign dram_we_no   = !we_low;
  assign dram_oe_no   = !((st_q == S_CASL) && !we_q);
  assign dram_addr_o  = col_ph ? addr_q[RW-1:0] : addr_q[AW-1:RW];
  assign dram_dq_o    = wd_q;
  assign dram_dq_oe_o = we_low;

  // R9
  dq_vs_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dram_dq_oe_o |-> dram_oe_no);

  // R8
  early_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(dram_cas_no) && !dram_we_no) |-> !$past(dram_we_no));

  // R10
  ref_cbr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_ack_o |=> (!dram_cas_no && dram_ras_no));

  // R4
  hit_no_ras_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == S_IDLE) && pend_q && row_hit) |=> !dram_ras_no);
endmodule

// File: tb/edo_dram_seq_bench.sv
module edo_dram_seq_bench;
  localparam int T_RP = 4, T_RCD = 2, T_RAS = 6, T_CAS = 1, T_CP = 1;
  localparam int T_CSH = 5, T_WP = 1, T_CSR = 1, T_RAS_MAX = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0, req_we = 1'b0, req_early = 1'b0, ref_req = 1'b0;
  logic [19:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic        req_ready_o, rd_valid_o, ref_ack_o;
  logic [3:0]  rd_data_o, dq_o;
  logic [3:0]  dq_i = '0;
  logic        ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [9:0]  addr;

  edo_dram_seq #(.T_RAS_MAX(T_RAS_MAX)) u_edo_dram_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready_o), .req_addr_i(req_addr),
    .req_we_i(req_we), .req_early_i(req_early), .req_wdata_i(req_wdata),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .ref_req_i(ref_req), .ref_ack_o(ref_ack_o),
    .dram_ras_no(ras_n), .dram_cas_no(cas_n), .dram_we_no(we_n), .dram_oe_no(oe_n),
    .dram_addr_o(addr), .dram_dq_o(dq_o), .dram_dq_oe_o(dq_oe), .dram_dq_i(dq_i)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // DRAM pin model and timing monitor
  logic [3:0] mem [logic [19:0]];
  logic [3:0] shadow [logic [19:0]];
  logic [3:0] exp_q [$];
  logic [9:0] row_m = '0, col_m = '0;
  logic pr = 1'b1, pc = 1'b1, pw = 1'b1, prv = 1'b0;
  int cyc = 0, t_rf = -1000, t_rr = -1000, t_cf = -1000, t_cr = -1000;
  int ras_falls = 0, cbr_cnt = 0, oe_viol = 0;
  bit in_cbr = 0, ref_seen = 0;

  function automatic logic [3:0] rd_arr(input logic [19:0] a, input bit sh);
    if (sh) return shadow.exists(a) ? shadow[a] : 4'h0;
    return mem.exists(a) ? mem[a] : 4'h0;
  endfunction

  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (pr && !ras_n) begin
      chk(cyc - t_rr >= T_RP, "R3 tRP", cyc - t_rr, T_RP);
      if (!cas_n) begin
        cbr_cnt++; in_cbr = 1;
        chk(ref_seen, "R10 refresh without ack", 0, 1);
        ref_seen = 0;
      end else begin
        row_m = addr; ras_falls++;
      end
      t_rf = cyc;
    end
    if (!pr && ras_n) begin
      chk(cyc - t_rf >= T_RAS, "R3 tRAS", cyc - t_rf, T_RAS);
      chk(cyc - t_rf <= T_RAS_MAX, "R6 RAS low max", cyc - t_rf, T_RAS_MAX);
      if (!in_cbr) chk(cyc - t_cf >= T_CSH, "R11 tCSH", cyc - t_cf, T_CSH);
      in_cbr = 0; t_rr = cyc;
    end
    if (pc && !cas_n && !ras_n && !pr) begin
      col_m = addr;
      chk(cyc - t_rf >= T_RCD, "R3 tRCD", cyc - t_rf, T_RCD);
      chk(cyc - t_cr >= T_CP, "R4 tCP", cyc - t_cr, T_CP);
      if (!we_n) begin
        chk(!pw, "R8 WE low before CAS", pw, 0);
        chk(oe_n && dq_oe, "R8 OE high and data driven", oe_n, 1);
        mem[{row_m, col_m}] = dq_o;
      end
      t_cf = cyc;
    end
    if (!pc && cas_n && !ras_n) begin
      chk(cyc - t_cf >= T_CAS, "R4 tCAS", cyc - t_cf, T_CAS);
      t_cr = cyc;
    end
    if (pw && !we_n && !cas_n && !pc && !ras_n) begin
      chk(oe_n && dq_oe, "R9 delayed write drive", dq_oe, 1);
      mem[{row_m, col_m}] = dq_o;
    end
    if (dq_oe && !oe_n) oe_viol++;
    if (rd_valid_o) begin
      chk(!pc && cas_n, "R7 valid with CAS rise", cas_n, 1);
      chk(!prv, "R7 single-cycle valid", prv, 0);
      if (exp_q.size() == 0) chk(0, "R12 unexpected read data", rd_data_o, 0);
      else begin
        logic [3:0] e;
        e = exp_q.pop_front();
        chk(rd_data_o == e, "R12 read data", rd_data_o, e);
      end
    end
    dq_i = (!ras_n && !cas_n && !oe_n && we_n) ? rd_arr({row_m, col_m}, 0) : 4'h0;
    pr = ras_n; pc = cas_n; pw = we_n; prv = rd_valid_o;
  end

  task automatic issue(input logic [19:0] a, input logic w, input logic e, input logic [3:0] d);
    @(negedge clk);
    req_addr = a; req_we = w; req_early = e; req_wdata = d; req_valid = 1'b1;
    while (!req_ready_o) @(negedge clk);
    @(posedge clk); #1 req_valid = 1'b0;
    if (w) shadow[a] = d;
    else exp_q.push_back(rd_arr(a, 1));
  endtask

  task automatic settle();
    @(negedge clk);
    while (!req_ready_o || exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic refresh();
    int c0;
    c0 = cbr_cnt;
    @(negedge clk); ref_req = 1'b1;
    while (!ref_ack_o) @(negedge clk);
    chk(ras_n && exp_q.size() == 0, "R10 ack with row closed, no access", ras_n, 1);
    ref_seen = 1;
    @(posedge clk); #1 ref_req = 1'b0;
    repeat (T_CSR + T_RAS + T_RP + 4) @(negedge clk);
    chk(cbr_cnt == c0 + 1, "R10 CAS-before-RAS cycle", cbr_cnt, c0 + 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int f0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ras_n && cas_n && we_n && oe_n, "R1 strobes idle in reset", {ras_n, cas_n, we_n, oe_n}, 15);
    chk(!dq_oe && !rd_valid_o && !ref_ack_o, "R1 no drive/valid in reset", {dq_oe, rd_valid_o, ref_ack_o}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready_o, "R1 ready after reset", req_ready_o, 1);

    // R2 R8: early write opens row, then R4 hit read
    f0 = ras_falls;
    issue(20'h0A5_03, 1, 1, 4'h9); settle();
    chk(row_m == 10'h029 && col_m == 10'h103, "R2 row/col on pins", {row_m, col_m}, {10'h029, 10'h103});
    chk(ras_falls == f0 + 1, "R5 first access activates", ras_falls, f0 + 1);
    issue(20'h0A5_03, 0, 0, 4'h0); settle();
    chk(ras_falls == f0 + 1, "R4 hit has no RAS edge", ras_falls, f0 + 1);
    // R9 delayed write in same row, then read back
    issue(20'h0A5_07, 1, 0, 4'h6); settle();
    issue(20'h0A5_07, 0, 0, 4'h0); settle();
    chk(ras_falls == f0 + 1, "R4 mixed page stays open", ras_falls, f0 + 1);
    // R5 miss
    issue(20'hF00_11, 1, 0, 4'hC); settle();
    chk(ras_falls == f0 + 2, "R5 miss reactivates once", ras_falls, f0 + 2);
    chk(row_m == 10'h3C0, "R2 new row on pins", row_m, 10'h3C0);
    issue(20'h0A5_03, 0, 0, 4'h0); settle();
    issue(20'hF00_11, 0, 0, 4'h0); settle();
    // R6 idle open row closes itself
    repeat (T_RAS_MAX + 10) @(negedge clk);
    chk(ras_n, "R6 idle row closed", ras_n, 1);
    // R10 refresh from open row
    issue(20'h123_45, 1, 1, 4'h3); settle();
    refresh();
    issue(20'h123_45, 0, 0, 4'h0); settle();

    // random mix over a few rows
    for (int i = 0; i < 300; i++) begin
      logic [19:0] a;
      logic [1:0] rs;
      rs = 2'($urandom_range(0, 3));
      a = {8'h5A, rs, 6'h00, 4'($urandom_range(0, 15))};
      if ($urandom_range(0, 19) == 0) refresh();
      else if ($urandom_range(0, 29) == 0) repeat ($urandom_range(1, T_RAS_MAX)) @(negedge clk);
      issue(a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)));
      settle();
    end
    repeat (5) @(negedge clk);
    chk(oe_viol == 0, "R9 data drive while OE low", oe_viol, 0);
    chk(exp_q.size() == 0, "R7 all reads returned", exp_q.size(), 0);
    finish_run();
  end
endmodule